// File: doc/BRIEF.md
# Pause-Width Bit Demodulator

This block recovers the downlink bit stream that a reader sends to a tag by gating its carrier. Each bit begins with a short carrier gap. A carrier-on stretch follows, and the distance from one gap to the next gives the bit value. The block runs on a one-cycle tick enable at the subcarrier rate and takes the raw carrier-present level, which it synchronizes itself. A `start` pulse arms a frame hunt. While hunting, the block advances an external keystream generator at a fixed slot rate until the first gap arrives. From that gap on, it measures every gap-to-gap interval and decodes one bit per interval.

The frames carry no length field and no stop marker. The only way a frame ends is a timing violation: an interval that is too short, or a wait that runs too long. If the number of bits gathered when that happens lies within the legal range, the frame is good. Otherwise it is an error. Each decoded bit is XORed with the keystream bit that the generator presents, and the generator is told to advance once per accepted bit. At the end, a one-cycle `done` pulse is raised. The frame word, its length and a tick timestamp of the frame end are ready at the same moment, and `err` qualifies the pulse.

Top module: `pw_demod`

## Requirements
- R1: After reset, `done`, `err`, `ks_adv`, `frame_len`, `frame_word` and `end_time` are all zero.
- R2: A gap-to-gap interval of more than 17 ticks decodes as 1, and one of 17 ticks or less decodes as 0 (13-tick and 21-tick nominal bits).
- R3: Bit k of the frame (k = 0 first received) is stored at `frame_word[k]` as the decoded bit XOR `ks_bit`. `ks_adv` pulses exactly once per accepted bit.
- R4: An interval of fewer than 4 ticks is a violation that ends the frame. That interval contributes no bit.
- R5: A violation is raised when a gap lasts 32 ticks or longer, or when a carrier-on stretch makes the interval reach 32 ticks without a new gap.
- R6: A violation with 6 to 23 bits gathered ends the frame with `err`=0. With fewer bits, `err`=1. A 24th gap-terminated bit ends the frame at once with `err`=1 and `frame_len`=23.
- R7: `start` causes one `ks_adv` at once. While hunting, one more follows every 21 ticks. If no gap has arrived by the 41st such slot boundary (tick 861), the hunt ends with `err`=1 and no advance on that boundary.
- R8: On a good frame, `end_time` equals the tick count of the last accepted gap's detection, plus 4, minus 2. The tick count is the number of ticks since reset, with the detecting tick included.
- R9: `done` is high for exactly one clock per frame, in the clock after the tick that ends the frame. `err` changes only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle subcarrier-rate enable |
| carrier_in | input | 1 | Asynchronous carrier level, 1 = carrier on, 0 = gap |
| start | input | 1 | Arms a frame hunt; ignored unless idle |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | One-cycle request to advance the keystream |
| frame_word | output | 23 | Received frame, first bit in bit 0 |
| frame_len | output | 5 | Number of accepted bits |
| done | output | 1 | One-cycle frame completion pulse |
| err | output | 1 | Error qualifier of the last `done` |
| end_time | output | 16 | Tick timestamp of the frame end |

## Verification
A carrier level changes at the block's inputs and becomes visible through the two-stage synchronizer by the next tick. The bench therefore drives one level per tick and counts ticks itself. It computes the tick on which each frame must end: 32 ticks after the last gap for an over-long wait, 2 after it for a short interval, the hunt's tick 861 for an empty channel, or the offending gap itself for a 24th bit. `done` must appear in the clock right after that tick. The monitor samples one nanosecond after each rising edge and compares the tick index it sees against the queued value. The advance count and the keystream-masked word are predicted from the hunt delay and a private model of the generator.

// File: rtl/pw_demod_pkg.sv
package pw_demod_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HUNT  = 2'd1,
    ST_GAP   = 2'd2,
    ST_CARR  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/pw_sync.sv
module pw_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pw_interval.sv
module pw_interval #(
  parameter int CNT_W   = 6,
  parameter int THRESH  = 17,
  parameter int MIN_T   = 4,
  parameter int MAX_T   = 31
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clear,
  output logic is_one,
  output logic too_short,
  output logic too_long
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_next;

  // saturating next count so that an idle line cannot wrap back to short
  assign cnt_next  = (cnt == CNT_TOP) ? cnt : cnt + 1'b1;
  assign is_one    = cnt_next >  CNT_W'(THRESH);
  assign too_short = cnt_next <  CNT_W'(MIN_T);
  assign too_long  = cnt_next >  CNT_W'(MAX_T);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick)    cnt <= cnt_next;
  end
endmodule

// File: rtl/pw_frame.sv
module pw_frame #(
  parameter int MAX_LEN = 23,
  parameter int LEN_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               load,
  input  logic               bit_in,
  output logic [MAX_LEN-1:0] word,
  output logic [LEN_W-1:0]   len
);
  genvar gi;
  generate
    for (gi = 0; gi < MAX_LEN; gi++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst || clr)                          word[gi] <= 1'b0;
        else if (load && len == LEN_W'(gi))      word[gi] <= bit_in;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) len <= '0;
    else if (load)  len <= len + 1'b1;
  end
endmodule

// File: rtl/pw_demod.sv
module pw_demod #(
  parameter int TICK_GAP   = 4,
  parameter int TICK_ZERO  = 13,
  parameter int TICK_ONE   = 21,
  parameter int MIN_LEN    = 6,
  parameter int MAX_LEN    = 23,
  parameter int HUNT_LIMIT = 41,
  parameter int PIPE_ADJ   = 2,
  parameter int STAMP_W    = 16,
  parameter int SYNC_STG   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               carrier_in,
  input  logic               start,
  input  logic               ks_bit,
  output logic               ks_adv,
  output logic [MAX_LEN-1:0] frame_word,
  output logic [4:0]         frame_len,
  output logic               done,
  output logic               err,
  output logic [STAMP_W-1:0] end_time
);
  import pw_demod_pkg::*;

  localparam int THRESH  = (TICK_ZERO + TICK_ONE) / 2;
  localparam int WAIT_MX = TICK_ONE * 3 / 2;
  localparam int CNT_W   = $clog2(WAIT_MX + 2);
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int SLOT_W  = $clog2(TICK_ONE);
  localparam int PER_W   = $clog2(HUNT_LIMIT);
  localparam logic [STAMP_W-1:0] END_ADJ = STAMP_W'(TICK_GAP - PIPE_ADJ);

  rx_state_t          state;
  logic               car;
  logic               is_one, too_short, too_long;
  logic               ivl_clr, frm_clr, frm_load;
  logic [SLOT_W-1:0]  slot_cnt;
  logic [PER_W-1:0]   slot_num;
  logic [STAMP_W-1:0] stamp, stamp_inc, last_gap;
  logic [LEN_W-1:0]   len;
  logic               len_full, len_ok;

  pw_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(carrier_in), .q(car)
  );

  pw_interval #(.CNT_W(CNT_W), .THRESH(THRESH), .MIN_T(TICK_GAP), .MAX_T(WAIT_MX)) u_ivl (
    .clk(clk), .rst(rst), .tick(tick), .clear(ivl_clr),
    .is_one(is_one), .too_short(too_short), .too_long(too_long)
  );

  pw_frame #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_frm (
    .clk(clk), .rst(rst), .clr(frm_clr), .load(frm_load),
    .bit_in(is_one ^ ks_bit), .word(frame_word), .len(len)
  );

  assign frame_len = 5'(len);
  assign stamp_inc = stamp + 1'b1;
  assign len_full  = (len == LEN_W'(MAX_LEN));
  assign len_ok    = (len >= LEN_W'(MIN_LEN)) && (len <= LEN_W'(MAX_LEN));
  assign frm_clr   = (state == ST_IDLE) && start;
  assign frm_load  = tick && (state == ST_CARR) && !car && !too_short && !len_full;
  assign ivl_clr   = (state == ST_IDLE) || (state == ST_HUNT) || frm_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      slot_cnt <= '0;
      slot_num <= '0;
      stamp    <= '0;
      last_gap <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      ks_adv   <= 1'b0;
      end_time <= '0;
    end else begin
      done   <= 1'b0;
      ks_adv <= 1'b0;
      if (tick) stamp <= stamp_inc;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_HUNT;
            slot_cnt <= '0;
            slot_num <= '0;
            ks_adv   <= 1'b1;
          end
        end
        ST_HUNT: begin
          if (tick) begin
            if (!car) begin
              state    <= ST_GAP;
              last_gap <= stamp_inc;
            end else if (slot_cnt == SLOT_W'(TICK_ONE - 1)) begin
              slot_cnt <= '0;
              if (slot_num == PER_W'(HUNT_LIMIT - 1)) begin
                state <= ST_IDLE;
                done  <= 1'b1;
                err   <= 1'b1;
              end else begin
                slot_num <= slot_num + 1'b1;
                ks_adv   <= 1'b1;
              end
            end else begin
              slot_cnt <= slot_cnt + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (too_long) begin
              state    <= ST_IDLE;
              done     <= 1'b1;
              err      <= !len_ok;
              end_time <= last_gap + END_ADJ;
            end else if (car) begin
              state <= ST_CARR;
            end
          end
        end
        ST_CARR: begin
          if (tick) begin
            if (!car) begin
              if (too_short) begin
                state    <= ST_IDLE;
                done     <= 1'b1;
                err      <= !len_ok;
                end_time <= last_gap + END_ADJ;
              end else if (len_full) begin
                state <= ST_IDLE;
                done  <= 1'b1;
                err   <= 1'b1;
              end else begin
                state    <= ST_GAP;
                last_gap <= stamp_inc;
                ks_adv   <= 1'b1;
              end
            end else if (too_long) begin
              state    <= ST_IDLE;
              done     <= 1'b1;
              err      <= !len_ok;
              end_time <= last_gap + END_ADJ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pw_demod_chk.sv
module pw_demod_chk #(
  parameter int MIN_LEN = 6,
  parameter int MAX_LEN = 23
) (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       start,
  input logic       ks_adv,
  input logic       done,
  input logic       err,
  input logic [4:0] frame_len
);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    $changed(err) |-> done);

  assert_good_len_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (frame_len >= 5'(MIN_LEN) && frame_len <= 5'(MAX_LEN)));

  assert_len_step_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_len != $past(frame_len)) |-> (frame_len == $past(frame_len) + 5'd1 || frame_len == 5'd0));

  assert_adv_cause_R7: assert property (@(posedge clk) disable iff (rst)
    ks_adv |-> ($past(tick) || $past(start)));

  assert_adv_not_done_R3: assert property (@(posedge clk) disable iff (rst)
    !(ks_adv && done));
endmodule

bind pw_demod pw_demod_chk #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .start(start), .ks_adv(ks_adv),
  .done(done), .err(err), .frame_len(frame_len)
);

// File: tb/sim_pw_demod.sv
`timescale 1ns/1ps
module sim_pw_demod;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        carrier_in = 1'b1;
  logic        start = 1'b0;
  logic        ks_bit;
  logic        ks_adv;
  logic [22:0] frame_word;
  logic [4:0]  frame_len;
  logic        done, err;
  logic [15:0] end_time;

  always #2 clk = ~clk;

  pw_demod u0 (
    .clk(clk), .rst(rst), .tick(tick), .carrier_in(carrier_in), .start(start),
    .ks_bit(ks_bit), .ks_adv(ks_adv), .frame_word(frame_word), .frame_len(frame_len),
    .done(done), .err(err), .end_time(end_time)
  );

  // private keystream generator model
  logic [7:0] lfsr = 8'hA5;
  assign ks_bit = lfsr[0];
  initial forever begin
    @(posedge clk);
    if (ks_adv) lfsr <= {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[4], lfsr[7:1]};
  end

  function automatic logic ks_at(input logic [7:0] seed, input int n);
    logic [7:0] s = seed;
    for (int i = 0; i < n; i++) s = {s[0] ^ s[2] ^ s[3] ^ s[4], s[7:1]};
    return s[0];
  endfunction

  typedef struct {
    string       tag;
    logic        e_err;
    int          e_len;
    logic [22:0] e_word;
    logic [15:0] e_end;
    int          e_tick;
    int          e_adv;
  } exp_t;
  exp_t sb[$];

  int checks = 0, fails = 0;
  int tnum = 0;
  int advc = 0;
  bit finished = 0;

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one tick during which the design sees carrier level lv
  task automatic one_tick(input logic lv);
    @(negedge clk); carrier_in = lv; tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); tick = 1'b1; tnum++;
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) one_tick(1'b1);
  endtask

  task automatic pulse_start();
    @(negedge clk); tick = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // endk: 0 long carrier, 1 short interval, 2 long gap, 3 overflow bit
  task automatic frame(input string tag, input int d, input int nb, input logic [31:0] data,
                       input int l0, input int l1, input int endk);
    exp_t it;
    int a, p, plast, t0, nacc;
    logic [7:0] seed;
    seed = lfsr;
    t0 = tnum;
    a = 1 + (d - 1) / 21;
    nacc = (nb > 23) ? 23 : nb;
    p = t0 + d;
    plast = p;
    it.e_word = '0;
    for (int j = 0; j < nb; j++) begin
      p = p + (data[j] ? l1 : l0);
      if (j < 23) begin
        plast = p;
        it.e_word[j] = data[j] ^ ks_at(seed, a + j);
      end
    end
    it.tag = tag;
    it.e_len = nacc;
    it.e_adv = a + nacc;
    it.e_end = 16'(plast + 2);
    if (endk == 3) begin
      it.e_err = 1'b1;
      it.e_tick = p;
    end else begin
      it.e_err = !(nb >= 6 && nb <= 23);
      it.e_tick = (endk == 1) ? plast + 2 : plast + 32;
    end
    sb.push_back(it);
    pulse_start();
    idle_ticks(d - 1);
    one_tick(1'b0);
    for (int j = 0; j < nb; j++) begin
      int len;
      len = data[j] ? l1 : l0;
      for (int k = 0; k < 3; k++) one_tick(1'b0);
      for (int k = 0; k < len - 4; k++) one_tick(1'b1);
      one_tick(1'b0);
    end
    if (endk == 0) begin
      for (int k = 0; k < 3; k++) one_tick(1'b0);
      idle_ticks(32);
    end else if (endk == 1) begin
      one_tick(1'b1);
      one_tick(1'b0);
    end else if (endk == 2) begin
      for (int k = 0; k < 34; k++) one_tick(1'b0);
    end
    idle_ticks(40);
  endtask

  // monitor: pops scoreboard items when a frame completes
  initial begin
    forever begin
      @(posedge clk); #1;
      if (start) advc = 0;
      if (ks_adv) advc++;
      if (done) begin
        if (sb.size() == 0) begin
          chk("R9 unexpected done", 1'b0, 1, 0);
        end else begin
          exp_t it;
          it = sb.pop_front();
          chk({it.tag, " R6 err"}, err == it.e_err, err, it.e_err);
          chk({it.tag, " R9 done tick"}, tnum == it.e_tick, tnum, it.e_tick);
          chk({it.tag, " R6 len"}, frame_len == 5'(it.e_len), frame_len, it.e_len);
          chk({it.tag, " R3 advances"}, advc == it.e_adv, advc, it.e_adv);
          if (!it.e_err) begin
            chk({it.tag, " R3 word"}, frame_word == it.e_word, frame_word, it.e_word);
            chk({it.tag, " R8 end time"}, end_time == it.e_end, end_time, it.e_end);
          end
        end
        @(posedge clk); #1;
        if (ks_adv) advc++;
        chk("R9 done width", done == 1'b0, done, 0);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog expired", 1'b0, 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", done == 1'b0, done, 0);
    chk("R1 err", err == 1'b0, err, 0);
    chk("R1 ks_adv", ks_adv == 1'b0, ks_adv, 0);
    chk("R1 frame_len", frame_len == 5'd0, frame_len, 0);
    chk("R1 frame_word", frame_word == 23'd0, frame_word, 0);
    chk("R1 end_time", end_time == 16'd0, end_time, 0);
    idle_ticks(5);
    // R2 threshold: 17-tick intervals give 0, 18-tick give 1; R5 long carrier end
    frame("R2 boundary", 5, 8, 32'h0000_00B2, 17, 18, 0);
    // R7 hunt crosses one slot boundary, R6 minimum length
    frame("R7 hunt slot", 30, 6, 32'h0000_002D, 13, 21, 0);
    // R6 too few bits
    frame("R6 short frame", 4, 5, 32'h0000_0015, 13, 21, 0);
    // R6 maximum length
    frame("R6 max frame", 3, 23, 32'h0055_AA3C, 13, 21, 0);
    // R6 overflow bit
    frame("R6 overflow", 3, 24, 32'h00F0_0F69, 13, 21, 3);
    // R4 short interval ends a legal frame
    frame("R4 short ok", 2, 7, 32'h0000_0049, 13, 21, 1);
    // R4 short interval with too few bits
    frame("R4 short err", 2, 2, 32'h0000_0002, 13, 21, 1);
    // R5 long gap
    frame("R5 long gap", 6, 3, 32'h0000_0005, 13, 21, 2);
    // R7 hunt abort: 41 slots with no gap
    begin
      exp_t it;
      it.tag = "R7 hunt abort";
      it.e_err = 1'b1; it.e_len = 0; it.e_word = '0; it.e_end = '0;
      it.e_tick = tnum + 861; it.e_adv = 41;
      sb.push_back(it);
      pulse_start();
      idle_ticks(880);
    end
    idle_ticks(10);
    chk("R9 all frames reported", sb.size() == 0, sb.size(), 0);
    summary();
  end
endmodule